// File: doc/BRIEF.md
# Low-Power Edge Wake-Up Controller

This block watches a small set of general-purpose input pins while the device rests in its low-power standby state and turns qualified edges on them into a wake request. Software assigns each pin a role: no wake function, a wake that targets the fully active state, or a wake that targets the reduced controller-only state. Two per-pin ignore bits choose whether rising edges, falling edges or both take part. Each pin passes through a synchronizer and a pulse-width qualifier before its edges are judged.

A wake is taken only when the device is in standby, standby was entered through a register-issued off request, the sleep-control signals are masked, and the enable-pin on request is still asserted. An accepted edge sets a sticky per-pin interrupt flag. It raises the wake request and pulls the active-low interrupt output low. The request holds, and the next-state output points at the wake target, until software clears every set flag. From then on the next state follows the two sleep-control inputs.

Top module: `lpwk_ctrl`

## Requirements
- R1: After reset `int_flag` is all zero, `wake_req` is 0, `irq_n` is 1, and all pin roles are "none" with both ignore bits cleared.
- R2: A pin level change is accepted as an edge only when the new level is held at the pin for at least PW_MIN consecutive clock cycles (default 4). A pulse of PW_MIN-1 cycles sets no flag.
- R3: When a pin's rise-ignore bit is 1, a rising edge on it sets no flag. When its fall-ignore bit is 1, a falling edge on it sets no flag.
- R4: An edge sets no flag unless `stby_active`, `stby_by_reg_off`, `sleep_ctl_masked` and `en_on_req` are all 1 when the edge is accepted.
- R5: A pin whose role code is 0 (none) never sets a flag. Role code 1 targets active, role code 2 targets controller-only, and code 3 acts as none.
- R6: A qualified edge on pin i sets `int_flag[i]` and raises `wake_req`. `irq_n` goes low one cycle after the flag sets.
- R7: A set flag stays set until a 1 is written to its bit of `int_clr`. `wake_req` is the OR of all flags.
- R8: While `wake_req` is 1, `next_state` is 1 (active) if a set flag came from a pin with role 1, and 2 (controller-only) otherwise. It is never 0 (standby).
- R9: When edges on an active-target pin and a controller-only pin are accepted in the same cycle, both flags set and `next_state` is 1. After only the active-target flag is cleared, `next_state` becomes 2.
- R10: While `wake_req` is 0, `next_state` follows `sleep_ctl`: 2'b11 gives 1 (active), 2'b10 or 2'b01 gives 2 (controller-only), and 2'b00 gives 0 (standby).
- R11: `irq_n` returns to 1 in the cycle after the last set flag is cleared. In the cycle the flags clear it is still 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wk_pin | input | NPIN | Raw wake-capable pin levels |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | SELW | Pin index for the configuration write |
| cfg_role | input | 2 | Role code: 0 none, 1 wake to active, 2 wake to controller-only |
| cfg_rise_ign | input | 1 | 1 = ignore rising edges on the selected pin |
| cfg_fall_ign | input | 1 | 1 = ignore falling edges on the selected pin |
| int_clr | input | NPIN | Write-one-to-clear strobes for the interrupt flags |
| stby_active | input | 1 | Device sits in low-power standby |
| stby_by_reg_off | input | 1 | Standby was entered through a register off request |
| sleep_ctl_masked | input | 1 | Sleep-control signals are masked |
| en_on_req | input | 1 | Enable-pin on request still asserted |
| sleep_ctl | input | 2 | Two sleep-control inputs |
| int_flag | output | NPIN | Sticky per-pin interrupt flags |
| irq_n | output | 1 | Active-low interrupt output |
| wake_req | output | 1 | Internal wake request |
| next_state | output | 2 | Selected power state: 0 standby, 1 active, 2 controller-only |

## Verification
An edge on the active-target pin and an edge on the controller-only pin can be accepted in the same clock cycle. The two then compete for `next_state`. The bench provokes this by moving both pins on the same falling clock edge, so both go through synchronizer and qualifier in lockstep. It then judges that both flags are set and that the target is active. Clearing only the active-target flag must leave the request up with the target dropped to controller-only. This shows that the priority is resolved from the set flags and not from a one-time decision.

// File: rtl/lpwk_pkg.sv
`timescale 1ns/1ps
package lpwk_pkg;
   typedef enum logic [1:0] {
      ROLE_OFF = 2'd0,
      ROLE_ACT = 2'd1,
      ROLE_CTL = 2'd2
   } wk_role_e;

   typedef enum logic [1:0] {
      NS_STBY   = 2'd0,
      NS_ACTIVE = 2'd1,
      NS_CTRL   = 2'd2
   } nxt_state_e;

   typedef struct packed {
      wk_role_e role;
      logic     rise_ign;
      logic     fall_ign;
   } pin_cfg_s;
endpackage

// File: rtl/lpwk_edge.sv
`timescale 1ns/1ps
module lpwk_edge #(
   parameter int SYNC_STAGES = 2,
   parameter int PW_MIN      = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("lpwk_edge: SYNC_STAGES must be at least 2");
   end
   if (PW_MIN < 1) begin : g_bad_pw
      $error("lpwk_edge: PW_MIN must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   s;
   logic                   lvl_q;
   logic                   accept;
   logic                   rise_q, fall_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
   end
   assign s = sync_q[SYNC_STAGES-1];

   if (PW_MIN == 1) begin : g_direct
      assign accept = (s != lvl_q);
   end else begin : g_counted
      localparam int CW = $clog2(PW_MIN);
      localparam logic [CW-1:0] CMAX = CW'(PW_MIN - 1);
      logic [CW-1:0] cnt_q;
      assign accept = (s != lvl_q) && (cnt_q == CMAX);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   cnt_q <= '0;
         else if (s == lvl_q || accept) cnt_q <= '0;
         else                           cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= 1'b0;
         rise_q <= 1'b0;
         fall_q <= 1'b0;
      end else begin
         if (accept) lvl_q <= s;
         rise_q <= accept & s;
         fall_q <= accept & ~s;
      end
   end

   assign rise = rise_q;
   assign fall = fall_q;

   AST_EDGE_EXCL:   assert property (@(posedge clk) disable iff (!rst_n)
                       $onehot0({rise, fall}));                        // R2
   AST_RISE_LEVEL:  assert property (@(posedge clk) disable iff (!rst_n)
                       rise |-> ($past(s) && lvl_q));                   // R2
   AST_FALL_LEVEL:  assert property (@(posedge clk) disable iff (!rst_n)
                       fall |-> (!$past(s) && !lvl_q));                 // R2
endmodule

// File: rtl/lpwk_flags.sv
`timescale 1ns/1ps
module lpwk_flags #(
   parameter int NPIN = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIN-1:0] set_ev,
   input  logic [NPIN-1:0] set_act,
   input  logic [NPIN-1:0] clr,
   output logic [NPIN-1:0] flag,
   output logic [NPIN-1:0] act_flag,
   output logic            irq_n
);
   logic [NPIN-1:0] flag_q;
   logic [NPIN-1:0] tgt_q;
   logic            irq_n_q;

   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q[i] <= 1'b0;
            tgt_q[i]  <= 1'b0;
         end else begin
            if (set_ev[i]) begin
               flag_q[i] <= 1'b1;
               tgt_q[i]  <= set_act[i];
            end else if (clr[i]) begin
               flag_q[i] <= 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_n_q <= 1'b1;
      else        irq_n_q <= ~|flag_q;
   end

   assign flag     = flag_q;
   assign act_flag = flag_q & tgt_q;
   assign irq_n    = irq_n_q;

   AST_FLAG_SET:   assert property (@(posedge clk) disable iff (!rst_n)
                      |set_ev |=> ((flag_q & $past(set_ev)) == $past(set_ev)));           // R6
   AST_FLAG_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
                      |flag_q |=> ((flag_q & $past(flag_q & ~clr)) == $past(flag_q & ~clr))); // R7
   AST_IRQ_LAG:    assert property (@(posedge clk) disable iff (!rst_n)
                      $fell(|flag_q) |-> !irq_n);                                         // R11
endmodule

// File: rtl/lpwk_sel.sv
`timescale 1ns/1ps
module lpwk_sel
   import lpwk_pkg::*;
(
   input  logic       wake_req,
   input  logic       any_act,
   input  logic [1:0] sleep_ctl,
   output logic [1:0] next_state
);
   nxt_state_e ns;

   always_comb begin
      if (wake_req) begin
         ns = any_act ? NS_ACTIVE : NS_CTRL;
      end else begin
         unique case (sleep_ctl)
            2'b11:   ns = NS_ACTIVE;
            2'b00:   ns = NS_STBY;
            default: ns = NS_CTRL;
         endcase
      end
   end

   assign next_state = ns;
endmodule

// File: rtl/lpwk_ctrl.sv
`timescale 1ns/1ps
module lpwk_ctrl
   import lpwk_pkg::*;
#(
   parameter int NPIN        = 2,
   parameter int SYNC_STAGES = 2,
   parameter int PW_MIN      = 4,
   localparam int SELW       = (NPIN > 1) ? $clog2(NPIN) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIN-1:0] wk_pin,
   input  logic            cfg_wr,
   input  logic [SELW-1:0] cfg_sel,
   input  logic [1:0]      cfg_role,
   input  logic            cfg_rise_ign,
   input  logic            cfg_fall_ign,
   input  logic [NPIN-1:0] int_clr,
   input  logic            stby_active,
   input  logic            stby_by_reg_off,
   input  logic            sleep_ctl_masked,
   input  logic            en_on_req,
   input  logic [1:0]      sleep_ctl,
   output logic [NPIN-1:0] int_flag,
   output logic            irq_n,
   output logic            wake_req,
   output logic [1:0]      next_state
);
   if (NPIN < 1) begin : g_bad_npin
      $error("lpwk_ctrl: NPIN must be at least 1");
   end

   pin_cfg_s        cfg_q [NPIN];
   logic [NPIN-1:0] rise, fall, ev, is_act, act_flag;
   logic            qual_ok;

   assign qual_ok = stby_active & stby_by_reg_off & sleep_ctl_masked & en_on_req;

   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_q[i] <= '{role: ROLE_OFF, rise_ign: 1'b0, fall_ign: 1'b0};
         end else if (cfg_wr && cfg_sel == SELW'(i)) begin
            cfg_q[i] <= '{role: wk_role_e'(cfg_role),
                          rise_ign: cfg_rise_ign,
                          fall_ign: cfg_fall_ign};
         end
      end

      lpwk_edge #(
         .SYNC_STAGES (SYNC_STAGES),
         .PW_MIN      (PW_MIN)
      ) u_edge (
         .clk   (clk),
         .rst_n (rst_n),
         .pin   (wk_pin[i]),
         .rise  (rise[i]),
         .fall  (fall[i])
      );

      assign is_act[i] = (cfg_q[i].role == ROLE_ACT);
      assign ev[i] = qual_ok
                   & ((cfg_q[i].role == ROLE_ACT) | (cfg_q[i].role == ROLE_CTL))
                   & ((rise[i] & ~cfg_q[i].rise_ign) | (fall[i] & ~cfg_q[i].fall_ign));
   end

   lpwk_flags #(.NPIN(NPIN)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_ev   (ev),
      .set_act  (is_act),
      .clr      (int_clr),
      .flag     (int_flag),
      .act_flag (act_flag),
      .irq_n    (irq_n)
   );

   assign wake_req = |int_flag;

   lpwk_sel u_sel (
      .wake_req   (wake_req),
      .any_act    (|act_flag),
      .sleep_ctl  (sleep_ctl),
      .next_state (next_state)
   );

   AST_QUAL_GATE:   assert property (@(posedge clk) disable iff (!rst_n)
                       !qual_ok |=> ((int_flag & ~$past(int_flag)) == '0));      // R4
   AST_REQ_NOT_STBY: assert property (@(posedge clk) disable iff (!rst_n)
                       wake_req |-> (next_state != 2'd0));                      // R8
   AST_IRQ_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
                       (wake_req && $past(wake_req)) |-> !irq_n);               // R6
endmodule

// File: tb/lpwk_ctrl_tb.sv
`timescale 1ns/1ps
module lpwk_ctrl_tb_top;
   localparam int NPIN   = 2;
   localparam int PW_MIN = 4;
   localparam int SETTLE = 14;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NPIN-1:0] wk_pin = '0;
   logic            cfg_wr = 1'b0;
   logic [0:0]      cfg_sel = '0;
   logic [1:0]      cfg_role = '0;
   logic            cfg_rise_ign = 1'b0;
   logic            cfg_fall_ign = 1'b0;
   logic [NPIN-1:0] int_clr = '0;
   logic            stby_active = 1'b1;
   logic            stby_by_reg_off = 1'b1;
   logic            sleep_ctl_masked = 1'b1;
   logic            en_on_req = 1'b1;
   logic [1:0]      sleep_ctl = 2'b00;
   logic [NPIN-1:0] int_flag;
   logic            irq_n;
   logic            wake_req;
   logic [1:0]      next_state;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   lpwk_ctrl #(.NPIN(NPIN), .SYNC_STAGES(2), .PW_MIN(PW_MIN)) dut_i (
      .clk, .rst_n, .wk_pin, .cfg_wr, .cfg_sel, .cfg_role, .cfg_rise_ign,
      .cfg_fall_ign, .int_clr, .stby_active, .stby_by_reg_off,
      .sleep_ctl_masked, .en_on_req, .sleep_ctl, .int_flag, .irq_n,
      .wake_req, .next_state
   );

   // {sleep_ctl, expected next_state} with no wake request pending
   localparam logic [3:0] SLP_TBL [4] = '{
      {2'b11, 2'd1}, {2'b10, 2'd2}, {2'b01, 2'd2}, {2'b00, 2'd0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wcfg(input int sel, input logic [1:0] role, input logic ri, input logic fi);
      cfg_sel = 1'(sel); cfg_role = role; cfg_rise_ign = ri; cfg_fall_ign = fi;
      cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic clear(input logic [NPIN-1:0] m);
      int_clr = m;
      @(negedge clk);
      int_clr = '0;
   endtask

   initial begin
      #400000;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      // R1 reset state
      chk("R1 flags", int_flag, 0);
      chk("R1 wake_req", wake_req, 0);
      chk("R1 irq_n", irq_n, 1);
      // R1/R5: roles reset to none, so a qualified edge does nothing
      wk_pin[0] = 1'b1; cyc(SETTLE);
      chk("R1 R5 default role none", int_flag, 0);
      wk_pin[0] = 1'b0; cyc(SETTLE);

      // R10 table walk
      for (int k = 0; k < 4; k++) begin
         sleep_ctl = SLP_TBL[k][3:2];
         cyc(1);
         chk("R10 sleep map", next_state, SLP_TBL[k][1:0]);
      end
      sleep_ctl = 2'b00;

      wcfg(0, 2'd1, 1'b0, 1'b0);
      wcfg(1, 2'd2, 1'b0, 1'b0);

      // R2 short pulse rejected
      wk_pin[0] = 1'b1; cyc(PW_MIN - 1); wk_pin[0] = 1'b0; cyc(SETTLE);
      chk("R2 short pulse", int_flag, 0);

      // R2/R6/R8 held level accepted, active target
      wk_pin[0] = 1'b1; cyc(SETTLE);
      chk("R2 R6 flag set", int_flag, 2'b01);
      chk("R6 wake_req", wake_req, 1);
      chk("R6 irq_n low", irq_n, 0);
      chk("R8 target active", next_state, 1);
      cyc(20);
      chk("R7 held", wake_req, 1);

      // R7/R11 clear
      clear(2'b01);
      chk("R7 flag cleared", int_flag, 0);
      chk("R11 irq still low", irq_n, 0);
      cyc(1);
      chk("R11 irq released", irq_n, 1);
      chk("R10 after release", next_state, 0);

      // R3 rise ignored on pin1
      wcfg(1, 2'd2, 1'b1, 1'b0);
      wk_pin[1] = 1'b1; cyc(SETTLE);
      chk("R3 rise ignored", int_flag, 0);
      wcfg(1, 2'd2, 1'b0, 1'b0);
      wk_pin[1] = 1'b0; cyc(SETTLE);
      chk("R3 fall counted", int_flag, 2'b10);
      chk("R8 target ctrl", next_state, 2);
      clear(2'b10); cyc(1);

      // R3 fall ignored on pin0
      wcfg(0, 2'd1, 1'b0, 1'b1);
      wk_pin[0] = 1'b0; cyc(SETTLE);
      chk("R3 fall ignored", int_flag, 0);
      wcfg(0, 2'd1, 1'b0, 1'b0);

      // R4 each qualifying condition off in turn
      for (int k = 0; k < 4; k++) begin
         stby_active      = (k != 0);
         stby_by_reg_off  = (k != 1);
         sleep_ctl_masked = (k != 2);
         en_on_req        = (k != 3);
         wk_pin[0] = ~wk_pin[0]; cyc(SETTLE);
         chk("R4 unqualified edge", int_flag, 0);
         chk("R4 irq stays high", irq_n, 1);
      end
      stby_active = 1'b1; stby_by_reg_off = 1'b1;
      sleep_ctl_masked = 1'b1; en_on_req = 1'b1;

      // R5 role none and role code 3
      wcfg(0, 2'd0, 1'b0, 1'b0);
      wk_pin[0] = ~wk_pin[0]; cyc(SETTLE);
      chk("R5 role none", int_flag, 0);
      wcfg(0, 2'd3, 1'b0, 1'b0);
      wk_pin[0] = ~wk_pin[0]; cyc(SETTLE);
      chk("R5 role code 3", int_flag, 0);
      wcfg(0, 2'd1, 1'b0, 1'b0);

      // R9 simultaneous edges
      sleep_ctl = 2'b00;
      wk_pin = ~wk_pin; cyc(SETTLE);
      chk("R9 both flags", int_flag, 2'b11);
      chk("R9 active wins", next_state, 1);
      clear(2'b01); cyc(1);
      chk("R9 fall back ctrl", next_state, 2);
      chk("R7 other holds", wake_req, 1);
      clear(2'b10); cyc(1);
      chk("R11 all clear", irq_n, 1);
      chk("R10 standby", next_state, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule